// File: doc/BRIEF.md
# Tuner Register Bank over I2C

This block is a two-wire serial slave that holds the configuration bytes of an RF tuner and presents its status. Twelve writable bytes sit at pointer values 0x00 to 0x0B. Two read-only status bytes sit at 0x0C and 0x0D. The bus lines are sampled in the system clock domain, which must run at least sixteen times faster than the bus bit rate. The slave pulls SDA low through an open-drain enable.

A master writes by sending the device address with the write bit clear, then a pointer byte, then any number of data bytes. The slave stores each byte and then advances the pointer. To read, the master sets the pointer in the same way, issues a repeated START, and sends the address with the read bit set. The slave then sends bytes for as long as the master acknowledges them.

A write to pointer 0x02 sends a one-cycle start pulse to the VCO band-select logic. A sticky power-on flag in the first status byte reports that defaults have been loaded.

Top module: `tuner_regbank`

## Requirements
- R1: After reset the writable bytes hold 0x03 at 0x00, 0xB6 at 0x01, 0x04 at 0x05, 0xC0 at 0x06, 0xC8 at 0x07, 0x4B at 0x08, and 0x00 everywhere else. The power-on flag is 1.
- R2: The device address is the 7-bit value 110000s, where s is the level of `addr_sel`, followed by the R/W bit (0 = write, 1 = read). With s=0 the write byte is 0xC0; with s=1 it is 0xC2. An address byte that does not match gets no acknowledge, and the slave ignores all following bytes of that transaction.
- R3: In a write transaction the slave acknowledges the address, the pointer and every data byte. Data arrives MSB first. Each data byte goes to the current pointer, and the pointer then advances by one.
- R4: The pointer wraps from 0x0D to 0x00. A pointer byte greater than 0x0D selects 0x00.
- R5: Data bytes written to 0x0C or 0x0D are acknowledged and change nothing.
- R6: After a repeated START with a read address, the slave sends the byte at the pointer MSB first. While the master acknowledges, it advances the pointer (with the R4 wrap) and sends the next byte. A master NACK ends the burst and the slave releases SDA.
- R7: Status byte 0x0C is {power-on flag, `st_vco_ok`, `st_vco_idle`, `st_pll_lock`, 4'b0000}, with bit 7 first. Status byte 0x0D is {`st_band[4:0]`, `st_adc[2:0]`}.
- R8: The power-on flag clears only at a STOP that ends a transaction in which byte 0x0C was sent. A repeated START does not clear it. Once cleared, it stays 0 until reset.
- R9: A data byte stored at 0x02 produces exactly one high cycle on `autosel_start`. Writes to other pointers produce none.
- R10: A START that arrives in the middle of a byte abandons that byte and begins receiving a new address byte.
- R11: The slave changes its drive on SDA only while SCL is low. Its acknowledge holds SDA low for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel | input | 1 | Low address bit; the board pulls it high when the pin is left open |
| st_vco_ok | input | 1 | Band selection succeeded |
| st_vco_idle | input | 1 | Band selection not running |
| st_pll_lock | input | 1 | Synthesizer locked |
| st_band | input | 5 | Current VCO band readback |
| st_adc | input | 3 | Tuning-voltage ADC readback |
| cfg_flat | output | 96 | Writable bytes; byte k is at bits [8k+7:8k] |
| autosel_start | output | 1 | One-cycle pulse on a write to 0x02 |

## Verification
The hardest case to reach is the clearing rule for the power-on flag. The flag must survive a read of 0x0C that is followed only by a repeated START, and it must clear at the next STOP. The stimulus therefore chains two pointer-set-and-read passes over 0x0C with repeated STARTs, checks bit 7 both times, and then stops and reads again. A mid-byte abort is produced by driving three address bits and then forcing a repeated START before the byte completes. After that, a full write must land normally.

// File: rtl/tuner_regbank_pkg.sv
package tuner_regbank_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_CFG = 12;
    localparam int NUM_REG = 14;
    localparam int PTR_W   = $clog2(NUM_REG);
    localparam int CNT_W   = $clog2(BYTE_W);

    localparam logic [PTR_W-1:0] ADR_TRIG  = PTR_W'(2);
    localparam logic [PTR_W-1:0] ADR_STAT0 = PTR_W'(NUM_CFG);
    localparam logic [PTR_W-1:0] ADR_LAST  = PTR_W'(NUM_REG - 1);
    localparam logic [5:0]       DEV_ID_HI = 6'b110000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK_SET,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT
    } bus_state_e;

    typedef logic [NUM_CFG-1:0][BYTE_W-1:0] cfg_img_t;

    function automatic logic [BYTE_W-1:0] cfg_default(input int idx);
        case (idx)
            0:       return 8'h03;
            1:       return 8'hB6;
            5:       return 8'h04;
            6:       return 8'hC0;
            7:       return 8'hC8;
            8:       return 8'h4B;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cfg_img_t cfg_reset_image();
        cfg_img_t img;
        for (int i = 0; i < NUM_CFG; i++) begin
            img[i] = cfg_default(i);
        end
        return img;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
        return (p == ADR_LAST) ? '0 : p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/tr_line_sync.sv
module tr_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] lvl_prev
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-1:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign lvl[g]      = chain_q[STAGES-1];
        assign lvl_prev[g] = chain_q[STAGES];
    end

endmodule

// File: rtl/tr_bus_engine.sv
module tr_bus_engine
    import tuner_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              scl_p,
    input  logic              sda_s,
    input  logic              sda_p,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              rd_mark,
    output logic              stop_evt
);

    typedef struct packed {
        bus_state_e        st;
        bus_state_e        after;
        logic [CNT_W-1:0]  bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [PTR_W-1:0]  ptr;
        logic              sda_oe;
    } eng_t;

    eng_t s_d, s_q;

    logic scl_rise, scl_fall, start_evt;
    logic [BYTE_W-1:0] byte_in;
    logic byte_done;

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
    assign byte_in   = {s_q.shreg[BYTE_W-2:0], sda_s};
    assign byte_done = (s_q.bitcnt == CNT_W'(BYTE_W - 1));

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        wr_data = byte_in;
        rd_mark = 1'b0;
        if (start_evt) begin
            s_d.st     = ST_ADDR;
            s_d.bitcnt = '0;
            s_d.sda_oe = 1'b0;
        end else if (stop_evt) begin
            s_d.st     = ST_IDLE;
            s_d.sda_oe = 1'b0;
        end else begin
            unique case (s_q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        s_d.shreg  = byte_in;
                        s_d.bitcnt = s_q.bitcnt + CNT_W'(1);
                        if (byte_done) begin
                            s_d.bitcnt = '0;
                            s_d.st     = ST_ACK_SET;
                            if (s_q.st == ST_ADDR) begin
                                if (byte_in[BYTE_W-1:1] == {DEV_ID_HI, addr_sel}) begin
                                    s_d.after = byte_in[0] ? ST_TX : ST_PTR;
                                end else begin
                                    s_d.st = ST_IDLE;
                                end
                            end else if (s_q.st == ST_PTR) begin
                                s_d.after = ST_WDATA;
                                s_d.ptr   = (byte_in <= BYTE_W'(NUM_REG - 1))
                                            ? byte_in[PTR_W-1:0] : '0;
                            end else begin
                                s_d.after = ST_WDATA;
                                wr_en     = 1'b1;
                                s_d.ptr   = ptr_advance(s_q.ptr);
                            end
                        end
                    end
                end
                ST_ACK_SET: begin
                    if (scl_fall) begin
                        s_d.sda_oe = 1'b1;
                        s_d.st     = ST_ACK_HOLD;
                    end
                end
                ST_ACK_HOLD, ST_TX_NEXT: begin
                    if (scl_fall) begin
                        s_d.sda_oe = 1'b0;
                        s_d.bitcnt = '0;
                        if (s_q.st == ST_TX_NEXT || s_q.after == ST_TX) begin
                            s_d.shreg  = rd_data;
                            s_d.sda_oe = ~rd_data[BYTE_W-1];
                            s_d.st     = ST_TX;
                            rd_mark    = (s_q.ptr == ADR_STAT0);
                        end else begin
                            s_d.st = s_q.after;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (byte_done) begin
                            s_d.sda_oe = 1'b0;
                            s_d.bitcnt = '0;
                            s_d.st     = ST_TX_ACK;
                            s_d.ptr    = ptr_advance(s_q.ptr);
                        end else begin
                            s_d.shreg  = {s_q.shreg[BYTE_W-2:0], 1'b0};
                            s_d.sda_oe = ~s_q.shreg[BYTE_W-2];
                            s_d.bitcnt = s_q.bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        s_d.st = sda_s ? ST_IDLE : ST_TX_NEXT;
                    end
                end
                default: begin
                    s_d.st     = ST_IDLE;
                    s_d.sda_oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, after: ST_IDLE, bitcnt: '0,
                     shreg: '0, ptr: '0, sda_oe: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_oe  = s_q.sda_oe;
    assign wr_addr = s_q.ptr;
    assign rd_ptr  = s_q.ptr;

    // R11: a new pull on SDA starts only in a cycle that follows a low SCL sample
    assert_drive_on_low_scl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sda_oe) |-> !$past(scl_s));

    // R4: the pointer never leaves the implemented range
    assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ptr <= ADR_LAST);

    // R2: an unaddressed slave never holds the data line
    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && !$past(start_evt)) |-> !s_q.sda_oe);

endmodule

// File: rtl/tr_regfile.sv
module tr_regfile
    import tuner_regbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PTR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]         wr_data,
    input  logic [PTR_W-1:0]          rd_ptr,
    input  logic                      rd_mark,
    input  logic                      stop_evt,
    input  logic                      st_vco_ok,
    input  logic                      st_vco_idle,
    input  logic                      st_pll_lock,
    input  logic [4:0]                st_band,
    input  logic [2:0]                st_adc,
    output logic [BYTE_W-1:0]         rd_data,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_flat,
    output logic                      autosel_start
);

    typedef struct packed {
        cfg_img_t cfg;
        logic     por;
        logic     seen;
        logic     pulse;
    } rf_t;

    rf_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (wr_en) begin
            for (int i = 0; i < NUM_CFG; i++) begin
                if (wr_addr == PTR_W'(i)) r_d.cfg[i] = wr_data;
            end
            r_d.pulse = (wr_addr == ADR_TRIG);
        end
        if (rd_mark) r_d.seen = 1'b1;
        if (stop_evt) begin
            if (r_q.seen || rd_mark) r_d.por = 1'b0;
            r_d.seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cfg: cfg_reset_image(), por: 1'b1, seen: 1'b0, pulse: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (rd_ptr == ADR_STAT0) begin
            rd_data = {r_q.por, st_vco_ok, st_vco_idle, st_pll_lock, 4'b0000};
        end else begin
            rd_data = {st_band, st_adc};
        end
        for (int i = 0; i < NUM_CFG; i++) begin
            if (rd_ptr == PTR_W'(i)) rd_data = r_q.cfg[i];
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_out
        assign cfg_flat[g*BYTE_W +: BYTE_W] = r_q.cfg[g];
    end

    assign autosel_start = r_q.pulse;

    // R9: the start pulse only follows a write aimed at the trigger byte
    assert_trig_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse |-> ($past(wr_en) && $past(wr_addr) == ADR_TRIG));

    // R8: once cleared, the power-on flag never comes back
    assert_por_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.por |=> !r_q.por);

    // R5: writes aimed at the status bytes leave every stored byte alone
    assert_ro_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= ADR_STAT0) |=> $stable(r_q.cfg));

endmodule

// File: rtl/tuner_regbank.sv
module tuner_regbank
    import tuner_regbank_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    input  logic                      addr_sel,
    input  logic                      st_vco_ok,
    input  logic                      st_vco_idle,
    input  logic                      st_pll_lock,
    input  logic [4:0]                st_band,
    input  logic [2:0]                st_adc,
    output logic [NUM_CFG*BYTE_W-1:0] cfg_flat,
    output logic                      autosel_start
);

    logic [1:0]        lvl, lvl_prev;
    logic              wr_en, rd_mark, stop_evt;
    logic [PTR_W-1:0]  wr_addr, rd_ptr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    tr_line_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      ({scl_i, sda_i}),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    tr_bus_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lvl[1]),
        .scl_p    (lvl_prev[1]),
        .sda_s    (lvl[0]),
        .sda_p    (lvl_prev[0]),
        .addr_sel (addr_sel),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_ptr   (rd_ptr),
        .rd_mark  (rd_mark),
        .stop_evt (stop_evt)
    );

    tr_regfile u_rf (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rd_ptr        (rd_ptr),
        .rd_mark       (rd_mark),
        .stop_evt      (stop_evt),
        .st_vco_ok     (st_vco_ok),
        .st_vco_idle   (st_vco_idle),
        .st_pll_lock   (st_pll_lock),
        .st_band       (st_band),
        .st_adc        (st_adc),
        .rd_data       (rd_data),
        .cfg_flat      (cfg_flat),
        .autosel_start (autosel_start)
    );

endmodule

// File: tb/sim_tuner_regbank.sv
`timescale 1ns/1ps
module sim_tuner_regbank;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
    logic st_vco_ok = 1'b1, st_vco_idle = 1'b0, st_pll_lock = 1'b1;
    logic [4:0] st_band = 5'h13;
    logic [2:0] st_adc = 3'b101;
    logic sda_oe, autosel_start;
    logic [95:0] cfg_flat;
    wire sda_line = m_sda & ~sda_oe;

    tuner_regbank u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .st_vco_ok(st_vco_ok), .st_vco_idle(st_vco_idle),
        .st_pll_lock(st_pll_lock), .st_band(st_band), .st_adc(st_adc),
        .cfg_flat(cfg_flat), .autosel_start(autosel_start)
    );

    localparam int Q = 16;
    int checks = 0, errors = 0;
    int exp_pulses = 0, got_pulses = 0;
    bit cmp_en = 0, prev_pulse = 0, done = 0;
    logic [7:0] m_cfg [12];
    logic m_por = 1'b1, m_seen = 1'b0;
    int m_ptr = 0;
    logic [7:0] wq [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nxt(input int p);
        return (p == 13) ? 0 : p + 1;
    endfunction

    function automatic logic [7:0] exp_byte(input int p);
        if (p < 12) return m_cfg[p];
        if (p == 12) return {m_por, st_vco_ok, st_vco_idle, st_pll_lock, 4'h0};
        return {st_band, st_adc};
    endfunction

    // Every clock while the bus is quiet: stored bytes match the model (R3)
    always @(negedge clk) begin
        if (rst_n) begin
            if (autosel_start) begin
                got_pulses++;
                if (prev_pulse) chk(0, "R9", "pulse width", 2, 1);
            end
            prev_pulse = autosel_start;
        end
        if (cmp_en) begin
            bit ok = 1;
            int bad = 0;
            for (int i = 0; i < 12; i++) begin
                if (cfg_flat[i*8 +: 8] !== m_cfg[i]) begin
                    if (ok) bad = i;
                    ok = 0;
                end
            end
            chk(ok, "R3", "stored byte", cfg_flat[bad*8 +: 8], m_cfg[bad]);
        end
    end

    task automatic bus_start;
        m_sda = 1; m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(4);
    endtask

    task automatic bus_rstart;
        m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(4);
    endtask

    task automatic bus_stop;
        m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; w(Q); m_scl = 1; w(Q); m_scl = 0; w(4);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack_e, output bit ack_l);
        send_bits(b, 8);
        m_sda = 1; w(Q); m_scl = 1; w(2);
        ack_e = ~sda_line;
        w(Q - 4);
        ack_l = ~sda_line;
        w(2); m_scl = 0; w(4);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit ack);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            w(Q); m_scl = 1; w(Q/2); b[i] = sda_line; w(Q/2); m_scl = 0; w(4);
        end
        m_sda = ~ack; w(Q); m_scl = 1; w(Q); m_scl = 0; w(4); m_sda = 1;
    endtask

    function automatic logic [7:0] dev(input logic sel, input logic rw);
        return {6'b110000, sel, rw};
    endfunction

    // Write transaction with data taken from wq; expect_ack says whether the address matches
    task automatic wr_txn(input logic [7:0] dbyte, input logic [7:0] ptr,
                          input bit expect_ack, input bit use_rstart);
        bit ae, al;
        cmp_en = 0;
        if (use_rstart) bus_rstart; else bus_start;
        send_byte(dbyte, ae, al);
        chk(ae == expect_ack, "R2", "address ack", ae, expect_ack);
        chk(ae == al, "R11", "ack held through high phase", al, ae);
        send_byte(ptr, ae, al);
        chk(ae == expect_ack, "R3", "pointer ack", ae, expect_ack);
        if (expect_ack) m_ptr = (ptr > 8'h0D) ? 0 : int'(ptr);
        foreach (wq[k]) begin
            send_byte(wq[k], ae, al);
            chk(ae == expect_ack, "R3", "data ack", ae, expect_ack);
            if (expect_ack) begin
                if (m_ptr < 12) m_cfg[m_ptr] = wq[k];
                if (m_ptr == 2) exp_pulses++;
                m_ptr = nxt(m_ptr);
            end
        end
        bus_stop;
        w(8);
        chk(got_pulses == exp_pulses, "R9", "start pulse count", got_pulses, exp_pulses);
        cmp_en = 1;
    endtask

    task automatic rd_txn(input logic [7:0] ptr, input int n);
        bit ae, al;
        logic [7:0] b;
        cmp_en = 0;
        bus_start;
        send_byte(dev(addr_sel, 0), ae, al);
        send_byte(ptr, ae, al);
        m_ptr = (ptr > 8'h0D) ? 0 : int'(ptr);
        bus_rstart;
        send_byte(dev(addr_sel, 1), ae, al);
        chk(ae, "R6", "read address ack", ae, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k < n - 1);
            chk(b == exp_byte(m_ptr), (m_ptr >= 12) ? "R7" : "R6", "read byte",
                b, exp_byte(m_ptr));
            if (m_ptr == 12) m_seen = 1;
            m_ptr = nxt(m_ptr);
        end
        w(4);
        chk(sda_line == 1'b1, "R6", "released after NACK", sda_line, 1);
        bus_stop;
        if (m_seen) m_por = 0;
        m_seen = 0;
        w(8);
        cmp_en = 1;
    endtask

    initial begin
        bit ae, al;
        logic [7:0] b;
        for (int i = 0; i < 12; i++) m_cfg[i] = 8'h00;
        m_cfg[0] = 8'h03; m_cfg[1] = 8'hB6; m_cfg[5] = 8'h04;
        m_cfg[6] = 8'hC0; m_cfg[7] = 8'hC8; m_cfg[8] = 8'h4B;
        w(5);
        rst_n = 1;
        w(5);
        for (int i = 0; i < 12; i++)
            chk(cfg_flat[i*8 +: 8] == m_cfg[i], "R1", "reset byte", cfg_flat[i*8 +: 8], m_cfg[i]);
        chk(autosel_start == 0, "R1", "no pulse at reset", autosel_start, 0);
        cmp_en = 1;

        // R3, R9: burst over 0x00..0x03 includes the trigger byte
        wq = '{8'h12, 8'h34, 8'h56, 8'h78};
        wr_txn(dev(0, 0), 8'h00, 1, 0);
        // R9: divider bytes alone give no pulse
        wq = '{8'h9A, 8'hBC};
        wr_txn(dev(0, 0), 8'h00, 1, 0);
        // R4, R5: wrap through the status bytes back to 0x00
        wq = '{8'hE1, 8'h00, 8'h00, 8'h3C};
        wr_txn(dev(0, 0), 8'h0B, 1, 0);
        // R4: out-of-range pointer selects 0x00
        wq = '{8'h44};
        wr_txn(dev(0, 0), 8'h20, 1, 0);

        // R8: read 0x0C twice joined by repeated STARTs, flag survives until STOP
        cmp_en = 0;
        bus_start;
        send_byte(dev(0, 0), ae, al); send_byte(8'h0C, ae, al);
        bus_rstart; send_byte(dev(0, 1), ae, al);
        recv_byte(b, 0);
        chk(b == 8'hD0, "R8", "flag set before first STOP", b, 8'hD0);
        bus_rstart;
        send_byte(dev(0, 0), ae, al); send_byte(8'h0C, ae, al);
        bus_rstart; send_byte(dev(0, 1), ae, al);
        recv_byte(b, 0);
        chk(b[7] == 1'b1, "R8", "flag kept over repeated START", b[7], 1);
        bus_stop;
        m_por = 0;
        w(8);
        cmp_en = 1;
        rd_txn(8'h0C, 1);

        // R2: pin high selects 0xC2, 0xC0 then ignored
        addr_sel = 1; w(4);
        wq = '{8'hA5};
        wr_txn(dev(1, 0), 8'h09, 1, 0);
        wq = '{8'h11, 8'h22};
        wr_txn(dev(0, 0), 8'h09, 0, 0);
        addr_sel = 0; w(4);
        wq = '{8'h33};
        wr_txn(dev(1, 0), 8'h0A, 0, 0);

        // R6, R7: burst read across the status bytes and the wrap
        st_vco_idle = 1; st_band = 5'h0A; st_adc = 3'b010;
        rd_txn(8'h0A, 6);
        rd_txn(8'h03, 2);

        // R10: START after three address bits abandons the byte
        cmp_en = 0;
        bus_start;
        send_bits(8'hC0, 3);
        wq = '{8'h5A, 8'h6B};
        wr_txn(dev(0, 0), 8'h09, 1, 1);
        chk(cfg_flat[9*8 +: 8] == 8'h5A, "R10", "write after abort", cfg_flat[9*8 +: 8], 8'h5A);
        rd_txn(8'h09, 2);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule